// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a small word-wide register port. Software programs each counter with a start value and, optionally, a value to fall back to when the count runs out. That gives three usage patterns. In periodic mode the start and fall-back values are both N-1, so the counter expires every N ticks. In free-running mode both values are all-ones and the fall-back is on; software inverts the live value to get a rising timestamp. In one-shot mode the fall-back is off and the counter stops at zero.

Each counter takes its count tick from one of two sources. The first is an external fixed-reference tick strobe. The second is the block clock divided by 2^S, where S is a 3-bit field. Every expiry latches a per-timer event flag. Software clears a flag by writing a zero to its bit; ones have no effect. Each timer drives its own interrupt line, which is the flag gated by that timer's enable.

Each counter runs a three-state machine:
- `CH_OFF`: the timer is disabled and the value holds.
- `CH_COUNT`: the timer is counting.
- `CH_SPENT`: a one-shot timer has expired and sits at zero.

The transitions are:
- start (`CH_OFF`→`CH_COUNT`): enable is seen high.
- halt (`CH_COUNT`→`CH_OFF`): enable is seen low.
- finish (`CH_COUNT`→`CH_SPENT`): an expiry happens with the fall-back off.
- rearm (`CH_SPENT`→`CH_COUNT` or `CH_OFF`): the value register is written. The new state follows the enable bit.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: The byte offsets are control 0x00, flags 0x04, timer0 fall-back 0x10, timer0 value 0x14, timer1 fall-back 0x18 and timer1 value 0x1C. Control bits 0/2 enable timer0/1, bits 1/3 turn on their fall-back, bits 11/12 select the reference tick, and fields 21:19 and 24:22 hold the divider exponent. Undefined control bits read zero.
- R3: A counting timer lowers its value by one per tick. On a tick at zero it expires and, with the fall-back on, reloads, so a fall-back of L gives one expiry every L+1 ticks. The value is readable at any time.
- R4: With the reference tick deselected, a timer ticks once every 2^S clocks. The first tick lands 2^S clocks after counting starts.
- R5: With the reference tick selected, a timer changes only on cycles where `ref_tick` is high.
- R6: With the fall-back off, an expired timer holds zero and does not expire again until its value register is written. That write restarts counting.
- R7: An expiry sets flag bit 0 (timer0) or bit 8 (timer1). A flag-register write clears exactly the flags whose bits are zero and leaves the flags written as one.
- R8: `irq_o[i]` equals timer i's flag ANDed with its enable bit.
- R9: A value-register write in the same cycle as an expiry takes the written value and records no expiry.
- R10: An expiry in the same cycle as a clearing write leaves the flag set.
- R11: A disabled timer holds its value and its divider restarts from zero.
- R12: A timer first decrements on the second clock edge after the write that enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Fixed-reference tick strobe, one clock wide |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 2 | Per-timer interrupt level |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a value-register write and the tick that would expire the counter. The bench provokes it by starting a periodic timer with a fall-back of 5 and counting edges, so that the value write lands on the exact edge of the expected expiry. It then checks three things: the readback shows the written value, the interrupt stays low, and the next expiry arrives a full 21 edges later.

The second pair is an expiry and a clearing write to the flag register. The bench sets this up with a one-shot timer loaded with zero. It places the clearing write on the edge two cycles after the enable, where the expiry falls, and then checks that the flag is still set.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;

    localparam int DT_NUM_TMR = 2;
    localparam int DT_PSC_W   = 3;
    localparam int DT_ADDR_W  = 6;

    localparam logic [DT_ADDR_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [DT_ADDR_W-1:0] OFS_STAT = 6'h04;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_COUNT = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    function automatic int en_pos(int i);
        return 2 * i;
    endfunction

    function automatic int rl_pos(int i);
        return 2 * i + 1;
    endfunction

    function automatic int ref_pos(int i);
        return 11 + i;
    endfunction

    function automatic int psc_pos(int i);
        return 19 + DT_PSC_W * i;
    endfunction

    function automatic int flag_pos(int i);
        return 8 * i;
    endfunction

    function automatic logic [DT_ADDR_W-1:0] reload_ofs(int i);
        return DT_ADDR_W'(16 + 8 * i);
    endfunction

    function automatic logic [DT_ADDR_W-1:0] value_ofs(int i);
        return DT_ADDR_W'(20 + 8 * i);
    endfunction

endpackage

// File: rtl/dtmr_prescale.sv
`timescale 1ns/1ps
module dtmr_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               ref_sel,
    input  logic               ref_tick,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int CW = (1 << SHIFT_W) - 1;

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] div_mask;
    logic          div_hit;

    assign div_mask = (CW'(1) << shift) - CW'(1);
    assign div_hit  = (div_cnt == div_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!active || ref_sel || div_hit) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    assign tick = active && (ref_sel ? ref_tick : div_hit);

    // R11: an idle timer restarts its divider from zero
    assert_idle_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (div_cnt == '0));

    // R4: the divider never passes its terminal count
    assert_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ref_sel) |=> (div_cnt <= $past(div_mask)) || (div_cnt == '0));

endmodule

// File: rtl/dtmr_channel.sv
`timescale 1ns/1ps
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         autoreload,
    input  logic         tick,
    input  logic         val_we,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire,
    output logic         active
);
    ch_state_e    state_q, state_d;
    logic [W-1:0] count_q;
    logic         at_zero;

    assign active  = (state_q == CH_COUNT) && en;
    assign at_zero = (count_q == '0);
    assign expire  = active && tick && at_zero && !val_we;
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (en) state_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (!en) begin
                    state_d = CH_OFF;
                end else if (expire && !autoreload) begin
                    state_d = CH_SPENT;
                end
            end
            CH_SPENT: begin
                if (val_we) state_d = en ? CH_COUNT : CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (val_we) begin
            count_q <= wr_val;
        end else if (active && tick) begin
            if (!at_zero) begin
                count_q <= count_q - W'(1);
            end else if (autoreload) begin
                count_q <= reload_val;
            end
        end
    end

    // R9: a software write always lands, whatever the tick does
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        val_we |=> (count_q == $past(wr_val)));

    // R3: an expiry with the fall-back on reloads the counter
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && autoreload) |=> (count_q == $past(reload_val)));

    // R6: a spent one-shot holds its value until rewritten
    assert_spent_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT && !val_we) |=> $stable(count_q));

    // R11: a disabled timer keeps its value
    assert_off_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF && !val_we) |=> $stable(count_q));

endmodule

// File: rtl/dual_dntimer.sv
`timescale 1ns/1ps
module dual_dntimer
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick,
    input  logic [DT_ADDR_W-1:0] reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [DT_NUM_TMR-1:0] irq_o
);
    localparam int NT = DT_NUM_TMR;

    logic [NT-1:0]       en_q, rl_q, ref_q, flag_q;
    logic [DT_PSC_W-1:0] shift_q  [NT];
    logic [DATA_W-1:0]   reload_q [NT];
    logic [DATA_W-1:0]   count_w  [NT];
    logic [NT-1:0]       tick_w, expire_w, active_w;
    logic [NT-1:0]       reload_we, val_we;
    logic                ctrl_we, stat_we;
    logic [DATA_W-1:0]   ctrl_view, stat_view;

    assign ctrl_we = reg_we && (reg_addr == OFS_CTRL);
    assign stat_we = reg_we && (reg_addr == OFS_STAT);

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            reload_we[i] = reg_we && (reg_addr == reload_ofs(i));
            val_we[i]    = reg_we && (reg_addr == value_ofs(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            rl_q   <= '0;
            ref_q  <= '0;
            flag_q <= '0;
            for (int i = 0; i < NT; i++) begin
                shift_q[i]  <= '0;
                reload_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (ctrl_we) begin
                    en_q[i]    <= reg_wdata[en_pos(i)];
                    rl_q[i]    <= reg_wdata[rl_pos(i)];
                    ref_q[i]   <= reg_wdata[ref_pos(i)];
                    shift_q[i] <= reg_wdata[psc_pos(i) +: DT_PSC_W];
                end
                if (reload_we[i]) begin
                    reload_q[i] <= reg_wdata;
                end
                if (expire_w[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (stat_we && !reg_wdata[flag_pos(i)]) begin
                    flag_q[i] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        dtmr_prescale #(
            .SHIFT_W (DT_PSC_W)
        ) u_psc (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active_w[g]),
            .ref_sel  (ref_q[g]),
            .ref_tick (ref_tick),
            .shift    (shift_q[g]),
            .tick     (tick_w[g])
        );

        dtmr_channel #(
            .W (DATA_W)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en_q[g]),
            .autoreload (rl_q[g]),
            .tick       (tick_w[g]),
            .val_we     (val_we[g]),
            .wr_val     (reg_wdata),
            .reload_val (reload_q[g]),
            .count      (count_w[g]),
            .expire     (expire_w[g]),
            .active     (active_w[g])
        );

        assign irq_o[g] = flag_q[g] && en_q[g];

        // R10: an expiry always leaves its flag set, even against a clear
        assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            expire_w[g] |=> flag_q[g]);

        // R7: a zero written to the flag bit clears it when no expiry competes
        assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we && !reg_wdata[flag_pos(g)] && !expire_w[g]) |=> !flag_q[g]);
    end

    always_comb begin
        ctrl_view = '0;
        stat_view = '0;
        for (int i = 0; i < NT; i++) begin
            ctrl_view[en_pos(i)]                 = en_q[i];
            ctrl_view[rl_pos(i)]                 = rl_q[i];
            ctrl_view[ref_pos(i)]                = ref_q[i];
            ctrl_view[psc_pos(i) +: DT_PSC_W]    = shift_q[i];
            stat_view[flag_pos(i)]               = flag_q[i];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) reg_rdata = ctrl_view;
        if (reg_addr == OFS_STAT) reg_rdata = stat_view;
        for (int i = 0; i < NT; i++) begin
            if (reg_addr == reload_ofs(i)) reg_rdata = reload_q[i];
            if (reg_addr == value_ofs(i))  reg_rdata = count_w[i];
        end
    end

endmodule

// File: tb/dual_dntimer_tb_top.sv
`timescale 1ns/1ps
module dual_dntimer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    localparam logic [5:0] A_CTRL = 6'h00;
    localparam logic [5:0] A_STAT = 6'h04;
    localparam logic [5:0] A_RL0  = 6'h10;
    localparam logic [5:0] A_V0   = 6'h14;
    localparam logic [5:0] A_RL1  = 6'h18;
    localparam logic [5:0] A_V1   = 6'h1C;

    typedef struct {
        int tmr;
        int edge_n;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];
    logic [1:0] irq_prev = 2'b00;

    dual_dntimer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, expv, cyc);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_irq(input int t, input int e);
        exp_t item;
        item.tmr    = t;
        item.edge_n = e;
        exp_q.push_back(item);
    endtask

    task automatic pulse_ref();
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    // Monitor: every interrupt rise is matched against the expected expiry queue (R3, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int t = 0; t < 2; t++) begin
                if (irq_o[t] && !irq_prev[t]) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R3: unexpected irq rise timer %0d at edge %0d, expected none", t, cyc);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (e.tmr != t || e.edge_n != cyc) begin
                            errors++;
                            $display("FAIL R3: irq rise timer %0d edge %0d, expected timer %0d edge %0d",
                                     t, cyc, e.tmr, e.edge_n);
                        end
                    end
                end
            end
            irq_prev <= irq_o;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w;
        int w2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_STAT, v); chk("R1 flags", v, 32'h0);
        rd(A_RL0, v);  chk("R1 reload0", v, 32'h0);
        rd(A_V1, v);   chk("R1 value1", v, 32'h0);
        chk("R1 irq", {30'h0, irq_o}, 32'h0);

        // R2: control field positions and register offsets
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h01F8_1800);
        wr(A_CTRL, 32'h0);
        wr(A_RL1, 32'hA5A5_0001);
        rd(A_RL1, v); chk("R2 reload1", v, 32'hA5A5_0001);
        rd(A_RL0, v); chk("R2 reload0 untouched", v, 32'h0);
        wr(A_V1, 32'h0000_1234);
        rd(A_V1, v); chk("R11 value1 held while off", v, 32'h0000_1234);

        // R3: periodic, fall-back 9, divide-by-1
        wr(A_RL0, 32'd9);
        wr(A_V0, 32'd9);
        wr(A_CTRL, 32'h3);
        w = cyc;
        expect_irq(0, w + 11);
        expect_irq(0, w + 21);
        wait_to(w + 5);
        rd(A_V0, v); chk("R3 live value", v, 32'd5);
        wait_to(w + 13);
        wr(A_STAT, 32'hFFFF_FFFE);
        wait_to(w + 23);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFE);
        chk("R3 irq cleared", {30'h0, irq_o}, 32'h0);

        // R4, R6: one-shot on timer1, divide-by-4
        wr(A_V1, 32'd3);
        wr(A_CTRL, 32'h0080_0004);
        w = cyc;
        expect_irq(1, w + 17);
        wait_to(w + 8);
        rd(A_V1, v); chk("R4 divided count", v, 32'd2);
        wait_to(w + 20);
        wr(A_STAT, 32'hFFFF_FEFF);
        wait_to(w + 40);
        chk("R6 no second expiry", {31'h0, irq_o[1]}, 32'h0);
        rd(A_V1, v); chk("R6 holds zero", v, 32'h0);
        wr(A_V1, 32'd1);
        w2 = cyc;
        expect_irq(1, w2 + 8);
        wait_to(w2 + 10);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FEFF);

        // R7: both flags, write-zero-to-clear
        wr(A_V0, 32'h0);
        wr(A_V1, 32'h0);
        wr(A_CTRL, 32'h5);
        w = cyc;
        expect_irq(0, w + 2);
        expect_irq(1, w + 2);
        wait_to(w + 3);
        rd(A_STAT, v); chk("R7 both flags", v, 32'h0000_0101);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R7 ones ignored", v, 32'h0000_0101);
        wr(A_STAT, 32'hFFFF_FEFF);
        rd(A_STAT, v); chk("R7 clear bit 8 only", v, 32'h0000_0001);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk("R7 clear bit 0", v, 32'h0);
        wr(A_CTRL, 32'h0);

        // R8: interrupt gated by enable
        wr(A_V0, 32'h0);
        wr(A_CTRL, 32'h1);
        w = cyc;
        expect_irq(0, w + 2);
        wait_to(w + 3);
        wr(A_CTRL, 32'h0);
        chk("R8 irq masked", {31'h0, irq_o[0]}, 32'h0);
        rd(A_STAT, v); chk("R8 flag kept", v, 32'h0000_0001);
        wr(A_CTRL, 32'h1);
        expect_irq(0, cyc);
        chk("R8 irq restored", {31'h0, irq_o[0]}, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFE);

        // R9: value write on the expiry edge
        wr(A_RL0, 32'd5);
        wr(A_V0, 32'd5);
        wr(A_CTRL, 32'h3);
        w = cyc;
        wait_to(w + 6);
        wr(A_V0, 32'd20);
        rd(A_V0, v); chk("R9 written value wins", v, 32'd20);
        chk("R9 no expiry", {31'h0, irq_o[0]}, 32'h0);
        expect_irq(0, w + 28);
        wait_to(w + 30);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFE);

        // R10: clear and expiry on the same edge
        wr(A_V1, 32'h0);
        wr(A_CTRL, 32'h4);
        w = cyc;
        expect_irq(1, w + 2);
        wait_to(w + 1);
        wr(A_STAT, 32'hFFFF_FEFF);
        rd(A_STAT, v); chk("R10 set beats clear", v, 32'h0000_0100);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FEFF);

        // R5: reference tick source
        wr(A_V0, 32'd2);
        wr(A_CTRL, 32'h0000_0801);
        w = cyc;
        expect_irq(0, w + 9);
        wait_to(w + 2);
        pulse_ref();
        rd(A_V0, v); chk("R5 one ref tick", v, 32'd1);
        wait_to(w + 5);
        pulse_ref();
        rd(A_V0, v); chk("R5 two ref ticks", v, 32'd0);
        wait_to(w + 8);
        chk("R5 no expiry without ref tick", {31'h0, irq_o[0]}, 32'h0);
        pulse_ref();
        wait_to(w + 11);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFE);

        // R12, R11: start latency and hold on disable
        wr(A_RL1, 32'd30);
        wr(A_V1, 32'd30);
        wr(A_CTRL, 32'hC);
        w = cyc;
        rd(A_V1, v); chk("R12 no count on enable edge", v, 32'd30);
        wait_to(w + 2);
        rd(A_V1, v); chk("R12 first decrement", v, 32'd29);
        wait_to(w + 6);
        wr(A_CTRL, 32'h0);
        rd(A_V1, v); chk("R11 value at disable", v, 32'd24);
        wait_to(w + 17);
        rd(A_V1, v); chk("R11 value held", v, 32'd24);

        repeat (2) @(negedge clk);
        chk("R3 all expected expiries seen", exp_q.size(), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule